// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block connects a simple synchronous request port to an external asynchronous static RAM that is 128K words deep and 32 bits wide. A requester presents a command (read or write, a word address, write data and a four-bit byte mask) and the controller issues it once `req_ready` is high. On the memory side it drives four active-low per-byte chip enables, an active-low write strobe, an active-low output enable, a registered address and a shared tri-stated data bus.

Every memory-side control comes straight from a flip-flop, so none of them can glitch. The write strobe width, the read access wait and the bus turnaround gap are parameters counted in clock cycles. The controller walks the strobes through a fixed order. It holds the write data for one cycle after the write strobe rises, and it keeps every control idle for the turnaround gap after each command. As a result, the controller's bus driver and the memory's output driver are never active at the same time. Bytes are selected only through the per-byte chip enables. Read bytes whose enable was not asserted come back as zero.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and after reset, `req_ready` is 1, all four `mem_ce_n` bits are 1, `mem_we_n` and `mem_oe_n` are 1, the data bus is released and `rsp_valid` is 0. A reset taken in the middle of a write ends the write strobe at once.
- R2: A write accepted at clock edge E drives `mem_ce_n[i] = ~mask[i]` (bit i selects byte i, bits 8i+7..8i of the data) and holds `mem_we_n` low for exactly WR_PULSE cycles starting at E. It drives the write data on `mem_dq` during all of those cycles and during one more cycle after `mem_we_n` rises, with the chip enables unchanged.
- R3: While `mem_we_n` stays low, `mem_addr` and `mem_ce_n` do not change.
- R4: A read accepted at edge E holds `mem_oe_n` low with `mem_ce_n[i] = ~mask[i]` for exactly RD_WAIT cycles. On the edge that raises `mem_oe_n`, `rsp_valid` goes high for exactly one cycle with the captured word on `rsp_rdata`.
- R5: A write changes only the bytes whose mask bit is 1. The other bytes of the addressed word keep their contents.
- R6: The controller never drives `mem_dq` while `mem_oe_n` is low. After every command, `mem_ce_n`, `mem_we_n` and `mem_oe_n` all stay deasserted for exactly TURN cycles before `req_ready` returns to 1. `req_ready` is 0 from the accepting edge until then.
- R7: A `req_valid` presented while `req_ready` is 0 is ignored and does not change the memory.
- R8: In `rsp_rdata`, bytes whose mask bit is 0 read as zero. A mask of zero asserts no chip enable, writes nothing and returns 0.
- R9: `mem_we_n` and `mem_oe_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte select, bit i = byte i |
| req_ready | output | 1 | Controller idle, command accepted at next edge |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 32 | Read data, unselected bytes zero |
| mem_ce_n | output | 4 | Active-low per-byte chip enables |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 17 | Memory word address |
| mem_dq | inout | 32 | Shared data bus |

## Verification
The bench attaches a behavioural asynchronous memory to the bus and runs full-word writes, sparse byte masks (alternate bytes, a single top byte, an empty mask), the highest address, and reads with partial masks. Full-mask readback after a partial write separates correct byte merging from whole-word overwrites. Partial-mask reads separate zeroing of unselected lanes from passing through whatever is on the floating bus. Counting strobe-low and idle cycles at the pins separates exact pulse and turnaround timing from off-by-one sequencing. A command raised while the controller is busy, and a reset in the middle of a write strobe, show whether busy requests are ignored and whether reset releases the bus.

// File: rtl/sram_ctl_pkg.sv
// Package: shared types for the asynchronous SRAM controller.
// Assumes: included before every module of the controller.
package sram_ctl_pkg;

    // Width of one byte lane on the memory bus.
    localparam int LANE_W = 8;

    // Sequencer phases; GAP is the idle turnaround after every command.
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_WRITE = 3'd1,
        SEQ_HOLD  = 3'd2,
        SEQ_READ  = 3'd3,
        SEQ_GAP   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sram_cycle_timer.sv
// Module: sram_cycle_timer
// Down-counter that times one sequencer phase. Loading N makes expired
// rise after N further clock edges. Assumes load values fit in CNT_W bits.
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Phase ends when the count has reached zero.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/sram_byte_lane.sv
// Module: sram_byte_lane
// One byte of the data path: holds write data for the bus and captures read
// data, zeroing the byte when its chip enable was not asserted.
// Assumes capture coincides with the last cycle of the read access.
module sram_byte_lane
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] wdata_in,
    input  logic              lane_en,
    input  logic              capture,
    input  logic [LANE_W-1:0] dq_in,
    output logic [LANE_W-1:0] wdata_q,
    output logic [LANE_W-1:0] rdata_q
);

    // Latch write data when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (load) begin
            wdata_q <= wdata_in;
        end
    end

    // Capture the bus byte at the end of a read, zero if the lane was off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= lane_en ? dq_in : '0;
        end
    end

endmodule

// File: rtl/sram_seq.sv
// Module: sram_seq
// Command sequencer: orders the chip enables, write strobe, output enable and
// bus driver for each command, all from registers. Assumes WR_PULSE, RD_WAIT
// and TURN are each at least 1 and that the timer phase is loaded here.
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int WR_PULSE = 2,
    parameter int RD_WAIT  = 3,
    parameter int TURN     = 1,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_mask,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic [LANES-1:0] ce_n_q,
    output logic             we_n_q,
    output logic             oe_n_q,
    output logic             drive_q,
    output logic             rsp_valid_q
);

    seq_state_e state_q;

    // Idle is the only state in which a command can be taken.
    always_comb begin
        req_ready = (state_q == SEQ_IDLE);
        accept    = req_ready && req_valid;
        capture   = (state_q == SEQ_READ) && tmr_expired;
    end

    // Choose when to start a new timed phase and how long it lasts.
    always_comb begin
        tmr_load = accept || (state_q == SEQ_HOLD) || capture;
        if (state_q == SEQ_IDLE) begin
            tmr_val = req_write ? CNT_W'(WR_PULSE - 1) : CNT_W'(RD_WAIT - 1);
        end else begin
            tmr_val = CNT_W'(TURN - 1);
        end
    end

    // Phase transitions and registered memory-side controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            ce_n_q      <= '1;
            we_n_q      <= 1'b1;
            oe_n_q      <= 1'b1;
            drive_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        ce_n_q <= ~req_mask;
                        if (req_write) begin
                            we_n_q  <= 1'b0;
                            drive_q <= 1'b1;
                            state_q <= SEQ_WRITE;
                        end else begin
                            oe_n_q  <= 1'b0;
                            state_q <= SEQ_READ;
                        end
                    end
                end
                SEQ_WRITE: begin
                    if (tmr_expired) begin
                        we_n_q  <= 1'b1;
                        state_q <= SEQ_HOLD;
                    end
                end
                SEQ_HOLD: begin
                    ce_n_q  <= '1;
                    drive_q <= 1'b0;
                    state_q <= SEQ_GAP;
                end
                SEQ_READ: begin
                    if (tmr_expired) begin
                        oe_n_q      <= 1'b1;
                        ce_n_q      <= '1;
                        rsp_valid_q <= 1'b1;
                        state_q     <= SEQ_GAP;
                    end
                end
                SEQ_GAP: begin
                    if (tmr_expired) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Checker counter: length of the current write strobe in cycles.
    logic [15:0] we_low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
        end else if (!we_n_q) begin
            we_low_cnt <= we_low_cnt + 16'd1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    assert_we_oe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n_q && !oe_n_q));

    assert_no_drive_during_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_q && !oe_n_q));

    assert_turnaround_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n_q) |=> !drive_q);

    assert_rsp_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_q |=> !rsp_valid_q);

    assert_idle_controls_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n_q == '1 && we_n_q && oe_n_q && !drive_q));

    assert_ce_stable_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n_q && $past(!we_n_q)) |-> $stable(ce_n_q));

    assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_q) |-> (we_low_cnt == 16'(WR_PULSE)));

endmodule

// File: rtl/async_sram_ctrl.sv
// Module: async_sram_ctrl
// Top of the asynchronous SRAM controller: request port in, per-byte chip
// enables, strobes, address and tri-stated data bus out. Assumes the memory
// meets its access time within RD_WAIT cycles and needs at most WR_PULSE
// cycles of write strobe; all three timing parameters are at least 1.
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 32,
    parameter int WR_PULSE = 2,
    parameter int RD_WAIT  = 3,
    parameter int TURN     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_mask,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic [DW/8-1:0]   mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [AW-1:0]     mem_addr,
    inout  wire  [DW-1:0]     mem_dq
);

    localparam int LANES = DW / LANE_W;
    localparam int MAXC  = (WR_PULSE > RD_WAIT) ?
                           ((WR_PULSE > TURN) ? WR_PULSE : TURN) :
                           ((RD_WAIT > TURN) ? RD_WAIT : TURN);
    localparam int CNT_W = $clog2(MAXC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;
    logic             drive_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_bus;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_seq #(
        .LANES    (LANES),
        .WR_PULSE (WR_PULSE),
        .RD_WAIT  (RD_WAIT),
        .TURN     (TURN),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_mask    (req_mask),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .req_ready   (req_ready),
        .accept      (accept),
        .capture     (capture),
        .ce_n_q      (mem_ce_n),
        .we_n_q      (mem_we_n),
        .oe_n_q      (mem_oe_n),
        .drive_q     (drive_q),
        .rsp_valid_q (rsp_valid)
    );

    // Hold the command address for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
        end
    end

    assign mem_addr = addr_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_byte_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .wdata_in (req_wdata[g*LANE_W +: LANE_W]),
            .lane_en  (!mem_ce_n[g]),
            .capture  (capture),
            .dq_in    (mem_dq[g*LANE_W +: LANE_W]),
            .wdata_q  (wdata_bus[g*LANE_W +: LANE_W]),
            .rdata_q  (rsp_rdata[g*LANE_W +: LANE_W])
        );
    end

    // Drive the shared bus only during the write strobe and its hold cycle.
    assign mem_dq = drive_q ? wdata_bus : {DW{1'bz}};

    assert_addr_stable_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    assert_ready_low_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

endmodule

// File: tb/async_sram_ctrl_tb.sv
// Bench for async_sram_ctrl with a behavioural asynchronous memory on the bus.
module async_sram_ctrl_tb;

    localparam int WRP = 2;
    localparam int RDW = 3;
    localparam int TRN = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  mem_ce_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [16:0] mem_addr;
    wire  [31:0] mem_dq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    async_sram_ctrl #(.WR_PULSE(WRP), .RD_WAIT(RDW), .TURN(TRN)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // Behavioural memory: 1K words, writes on the rising write strobe.
    logic [31:0] model_mem [0:1023];
    logic        model_clear = 1'b0;

    always @(posedge mem_we_n or posedge model_clear) begin
        if (model_clear) begin
            for (int i = 0; i < 1024; i++) model_mem[i] = '0;
        end else begin
            for (int b = 0; b < 4; b++)
                if (!mem_ce_n[b]) model_mem[mem_addr[9:0]][b*8 +: 8] = mem_dq[b*8 +: 8];
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_model
        assign mem_dq[g*8 +: 8] = (!mem_ce_n[g] && mem_we_n && !mem_oe_n) ?
                                  model_mem[mem_addr[9:0]][g*8 +: 8] : 8'hzz;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Issue one command and check the pin sequence it produces.
    task automatic do_op(input bit wr, input logic [16:0] a, input logic [31:0] d,
                         input logic [3:0] m, input logic [31:0] exp);
        int n;
        int k;
        @(negedge clk);
        chk(req_ready == 1'b1, "R6 ready before command", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_addr == a, "R3 address", 32'(mem_addr), 32'(a));
        n = 0;
        if (wr) begin
            while (mem_we_n == 1'b0 && n < 64) begin
                chk(mem_ce_n == ~m, "R2 chip enables in write", 32'(mem_ce_n), 32'(~m));
                chk(mem_dq == d, "R2 write data on bus", mem_dq, d);
                chk(mem_oe_n == 1'b1, "R9 oe high in write", 32'(mem_oe_n), 32'd1);
                chk(mem_addr == a, "R3 address held in write", 32'(mem_addr), 32'(a));
                n++;
                @(negedge clk);
            end
            chk(n == WRP, "R2 write strobe width", 32'(n), 32'(WRP));
            chk(mem_ce_n == ~m, "R2 enables held in hold cycle", 32'(mem_ce_n), 32'(~m));
            chk(mem_dq == d, "R2 data held after strobe", mem_dq, d);
            @(negedge clk);
        end else begin
            while (mem_oe_n == 1'b0 && n < 64) begin
                chk(mem_ce_n == ~m, "R4 chip enables in read", 32'(mem_ce_n), 32'(~m));
                chk(mem_we_n == 1'b1, "R9 we high in read", 32'(mem_we_n), 32'd1);
                chk(rsp_valid == 1'b0, "R4 no early response", 32'(rsp_valid), 32'd0);
                n++;
                @(negedge clk);
            end
            chk(n == RDW, "R4 output enable width", 32'(n), 32'(RDW));
            chk(rsp_valid == 1'b1, "R4 response strobe", 32'(rsp_valid), 32'd1);
            chk(rsp_rdata == exp, "R4/R5/R8 read data", rsp_rdata, exp);
        end
        k = 0;
        while (!req_ready && k < 64) begin
            chk(mem_ce_n == 4'hF && mem_we_n && mem_oe_n, "R6 idle controls in gap",
                {26'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'h3F);
            k++;
            @(negedge clk);
        end
        chk(k == TRN, "R6 turnaround length", 32'(k), 32'(TRN));
        if (!wr) chk(rsp_valid == 1'b0, "R4 single-cycle strobe", 32'(rsp_valid), 32'd0);
    endtask

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [31:0] data;
        logic [3:0]  mask;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 17'h00010, 32'h11223344, 4'hF, 32'h0},         // R2 full word
        '{1'b0, 17'h00010, 32'h0,        4'hF, 32'h11223344},  // R4
        '{1'b1, 17'h00010, 32'hAABBCCDD, 4'h5, 32'h0},         // R5 bytes 0,2
        '{1'b0, 17'h00010, 32'h0,        4'hF, 32'h11BB33DD},  // R5 merge
        '{1'b0, 17'h00010, 32'h0,        4'hA, 32'h11003300},  // R8 partial read
        '{1'b1, 17'h1FFFF, 32'hCAFEF00D, 4'hF, 32'h0},         // top address
        '{1'b0, 17'h1FFFF, 32'h0,        4'hF, 32'hCAFEF00D},
        '{1'b1, 17'h00000, 32'h01020304, 4'h8, 32'h0},         // R5 top byte only
        '{1'b0, 17'h00000, 32'h0,        4'hF, 32'h01000000},
        '{1'b1, 17'h00010, 32'hFFFFFFFF, 4'h0, 32'h0},         // R8 empty mask write
        '{1'b0, 17'h00010, 32'h0,        4'hF, 32'h11BB33DD},  // R8 unchanged
        '{1'b0, 17'h00010, 32'h0,        4'h0, 32'h00000000}   // R8 empty mask read
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int k;
        // R1: outputs while held in reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && mem_ce_n == 4'hF && mem_we_n && mem_oe_n && !rsp_valid,
            "R1 reset state", {26'd0, req_ready, mem_ce_n, mem_we_n}, 32'h3F);
        rst_n = 1'b1;
        model_clear = 1'b1;
        @(negedge clk);
        model_clear = 1'b0;
        chk(req_ready && mem_ce_n == 4'hF && mem_we_n && mem_oe_n, "R1 after release",
            {26'd0, req_ready, mem_ce_n, mem_we_n}, 32'h3F);

        for (int v = 0; v < NV; v++) begin
            do_op(VECS[v].wr, VECS[v].addr, VECS[v].data, VECS[v].mask, VECS[v].exp);
        end

        // R7: a command raised while busy is ignored.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h40;
        req_wdata = 32'h55555555; req_mask = 4'hF;
        @(negedge clk);
        req_addr = 17'h20; req_wdata = 32'h77777777;
        chk(req_ready == 1'b0, "R7 busy during write", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (!req_ready && k < 64) begin k++; @(negedge clk); end
        do_op(1'b0, 17'h20, 32'h0, 4'hF, 32'h00000000);
        do_op(1'b0, 17'h40, 32'h0, 4'hF, 32'h55555555);

        // R1: reset in the middle of a write strobe.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h30;
        req_wdata = 32'h12345678; req_mask = 4'hF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_we_n == 1'b0, "R2 strobe started", 32'(mem_we_n), 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_we_n && mem_ce_n == 4'hF && mem_oe_n && req_ready,
            "R1 reset aborts write", {26'd0, req_ready, mem_ce_n, mem_we_n}, 32'h3F);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_op(1'b0, 17'h10, 32'h0, 4'hF, 32'h11BB33DD);

        finish_run();
    end

endmodule